// File: doc/BRIEF.md
# I2C Start/Stop Condition Detector

This block watches the two wires of an I2C bus and reports the two framing events that bracket every transfer. A falling edge on the data line while the clock line is high marks a start; a rising edge on the data line while the clock line is high marks a stop. Both raw lines first pass through a two-flop synchronizer. All timing qualification is counted in ticks of a count-source enable, not in system clock cycles. A clock line that is high for too short a time before or after the data edge therefore cannot produce an event, so glitches and marginal bus timing are filtered out.

Each accepted event gives a one-cycle pulse on its own output and a one-cycle pulse on a shared interrupt request. A bus-busy flag is set by a start and cleared by a stop. Software that services the shared interrupt reads the flag to learn which of the two events fired.

The qualifier is a five-state machine:
- `ST_SCL_LOW`: the clock is low.
- `ST_SETUP`: the clock is high and setup ticks are being counted.
- `ST_ARMED`: the setup time has been met, and a data edge is accepted.
- `ST_HOLD_FALL`: hold ticks are being counted after a falling data edge.
- `ST_HOLD_RISE`: hold ticks are being counted after a rising data edge.

Its transitions are:
- A clock rise moves `ST_SCL_LOW` to `ST_SETUP`.
- Reaching the setup count moves `ST_SETUP` to `ST_ARMED`.
- A data fall or rise moves `ST_ARMED` to `ST_HOLD_FALL` or `ST_HOLD_RISE`.
- Reaching the hold count fires the event and moves back to `ST_ARMED`.
- A data reversal during hold discards the event and moves to `ST_SETUP`.
- A clock fall moves any state to `ST_SCL_LOW`.
- A data edge in `ST_SETUP` restarts the setup count.

Top module: `i2c_cond_detect`

## Requirements
- R1: A falling SDA edge, with SCL high for at least 8 ticks before it and at least 8 ticks after it, produces exactly one `start_o` pulse.
- R2: A rising SDA edge, with the same qualification as in R1, produces exactly one `stop_o` pulse.
- R3: `irq_o` pulses for exactly one system clock cycle together with every `start_o` or `stop_o` pulse, and at no other time. `start_o` and `stop_o` are never high for two cycles in a row.
- R4: `busy_o` goes to 1 with each `start_o` pulse and goes to 0 with each `stop_o` pulse. It changes at no other time except reset.
- R5: An SDA edge that follows fewer than 6 ticks of SCL high (3 ticks in the tests) produces no pulse.
- R6: If SCL falls fewer than 6 ticks after a qualified SDA edge (3 ticks in the tests), the event is discarded: there is no pulse and `busy_o` does not change.
- R7: If SDA returns to its earlier level within the hold window, the event is discarded.
- R8: Setup and hold are counted only on cycles where `tick` is 1. With `tick` held at 0, no event is reported, however many system cycles pass.
- R9: SDA transitions while SCL is low never produce a pulse.
- R10: While reset is asserted and right after it, `start_o`, `stop_o`, `irq_o` and `busy_o` are 0. A reset while the bus is busy clears `busy_o`.
- R11: A start that arrives while `busy_o` is 1 (a repeated start) pulses `start_o` and leaves `busy_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-source enable; one tick per count cycle |
| sda_i | input | 1 | Raw SDA line |
| scl_i | input | 1 | Raw SCL line |
| start_o | output | 1 | One-cycle pulse on an accepted start |
| stop_o | output | 1 | One-cycle pulse on an accepted stop |
| busy_o | output | 1 | Bus-busy flag: set by start, cleared by stop |
| irq_o | output | 1 | Shared one-cycle interrupt request for both events |

## Verification
The hardest case to reach is a data edge that passes its setup check and then loses its hold window. There are two ways to lose it: SCL drops early, or SDA bounces back. Either way the machine is inside a hold state with a partly filled counter, and nothing at the ports shows that.

The stimulus reaches these cases directly. Vector rows give a long setup followed by a hold of only 3 ticks, and a directed test reverses SDA 2 ticks after the edge. Each case is judged by the absence of a pulse and by an unchanged busy flag.

A second hard case is the gating by `tick`. To reach it, the bench stops the tick generator entirely and holds SCL high for many system cycles around a data edge.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        ST_SCL_LOW   = 3'd0,
        ST_SETUP     = 3'd1,
        ST_ARMED     = 3'd2,
        ST_HOLD_FALL = 3'd3,
        ST_HOLD_RISE = 3'd4
    } cond_state_e;

endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
    parameter int              WIDTH     = 2,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= RESET_VAL;
        end else begin
            stage_q[0] <= raw_i;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RESET_VAL;
            end else begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cond_qualifier.sv
module cond_qualifier
    import i2c_cond_pkg::*;
#(
    parameter int SETUP_CYC = 6,
    parameter int HOLD_CYC  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sda_s,
    input  logic scl_s,
    output logic fire_start,
    output logic fire_stop
);

    localparam int MAX_CYC   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    cond_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sda_q;
    logic             sda_rise, sda_fall;
    logic             hold_done;

    assign sda_rise  = sda_s & ~sda_q;
    assign sda_fall  = ~sda_s & sda_q;
    assign hold_done = tick && (cnt_q == HOLD_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SCL_LOW;
            cnt_q   <= '0;
            sda_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sda_q   <= sda_s;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SCL_LOW: begin
                cnt_d = '0;
                if (scl_s) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                if (!scl_s) begin
                    state_d = ST_SCL_LOW;
                    cnt_d   = '0;
                end else if (sda_rise || sda_fall) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == SETUP_LAST) begin
                        state_d = ST_ARMED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_ARMED: begin
                cnt_d = '0;
                if (!scl_s)        state_d = ST_SCL_LOW;
                else if (sda_fall) state_d = ST_HOLD_FALL;
                else if (sda_rise) state_d = ST_HOLD_RISE;
            end
            ST_HOLD_FALL: begin
                if (!scl_s) begin
                    state_d = ST_SCL_LOW;
                    cnt_d   = '0;
                end else if (sda_rise) begin
                    state_d = ST_SETUP;
                    cnt_d   = '0;
                end else if (hold_done) begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD_RISE: begin
                if (!scl_s) begin
                    state_d = ST_SCL_LOW;
                    cnt_d   = '0;
                end else if (sda_fall) begin
                    state_d = ST_SETUP;
                    cnt_d   = '0;
                end else if (hold_done) begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_SCL_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire_start = 1'b0;
        fire_stop  = 1'b0;
        unique case (state_q)
            ST_HOLD_FALL: fire_start = scl_s && !sda_rise && hold_done;
            ST_HOLD_RISE: fire_stop  = scl_s && !sda_fall && hold_done;
            default: begin
                fire_start = 1'b0;
                fire_stop  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cond_flags.sv
module cond_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_start,
    input  logic fire_stop,
    output logic start_o,
    output logic stop_o,
    output logic irq_o,
    output logic busy_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            stop_o  <= 1'b0;
            irq_o   <= 1'b0;
            busy_o  <= 1'b0;
        end else begin
            start_o <= fire_start;
            stop_o  <= fire_stop;
            irq_o   <= fire_start | fire_stop;
            if (fire_start)     busy_o <= 1'b1;
            else if (fire_stop) busy_o <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
    parameter int SETUP_CYC   = 6,
    parameter int HOLD_CYC    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sda_i,
    input  logic scl_i,
    output logic start_o,
    output logic stop_o,
    output logic busy_o,
    output logic irq_o
);

    logic [1:0] line_s;
    logic       fire_start, fire_stop;

    cond_sync #(
        .WIDTH    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({scl_i, sda_i}),
        .sync_o(line_s)
    );

    cond_qualifier #(
        .SETUP_CYC(SETUP_CYC),
        .HOLD_CYC (HOLD_CYC)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sda_s     (line_s[0]),
        .scl_s     (line_s[1]),
        .fire_start(fire_start),
        .fire_stop (fire_stop)
    );

    cond_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_start(fire_start),
        .fire_stop (fire_stop),
        .start_o   (start_o),
        .stop_o    (stop_o),
        .irq_o     (irq_o),
        .busy_o    (busy_o)
    );

endmodule

// File: rtl/cond_detect_chk.sv
module cond_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic start_o,
    input logic stop_o,
    input logic busy_o,
    input logic irq_o
);

    // R3
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (start_o || stop_o));

    // R3
    events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R3
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    // R4
    busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    // R4
    busy_off_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);

    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(busy_o) |-> (start_o || stop_o));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!start_o && !stop_o && !irq_o && !busy_o));

endmodule

bind i2c_cond_detect cond_detect_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_o(start_o),
    .stop_o (stop_o),
    .busy_o (busy_o),
    .irq_o  (irq_o)
);

// File: tb/tb_i2c_cond_detect.sv
`timescale 1ns/1ps
module tb_i2c_cond_detect;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda = 1'b1;
    logic scl = 1'b1;
    logic tick_on = 1'b1;
    logic tick;
    logic start_o, stop_o, busy_o, irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    logic [1:0] div_q = '0;

    int cnt_start = 0, cnt_stop = 0, cnt_irq = 0;
    int n_wide = 0, n_irq_bad = 0;
    logic prev_start = 0, prev_stop = 0;

    always #4 clk = ~clk;

    always @(posedge clk) div_q <= div_q + 2'd1;
    assign tick = tick_on && (div_q == 2'd0);

    i2c_cond_detect dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sda_i(sda), .scl_i(scl),
        .start_o(start_o), .stop_o(stop_o), .busy_o(busy_o), .irq_o(irq_o)
    );

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o) cnt_start++;
            if (stop_o)  cnt_stop++;
            if (irq_o)   cnt_irq++;
            if ((start_o && prev_start) || (stop_o && prev_stop)) n_wide++;
            if (irq_o != (start_o || stop_o)) n_irq_bad++;
        end
        prev_start = start_o;
        prev_stop  = stop_o;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(negedge clk);
            if (tick) k++;
        end
    endtask

    // fields: [23:16] setup ticks, [15:8] hold ticks, [4] edge 0=fall 1=rise,
    // [2] expected start, [1] expected stop, [0] expected busy after
    localparam logic [23:0] VEC [9] = '{
        24'h09_09_05,   // R1 start
        24'h09_09_12,   // R2 stop
        24'h03_09_00,   // R5 short setup, fall
        24'h09_03_00,   // R6 short hold, fall
        24'h09_09_05,   // R1 start
        24'h09_09_05,   // R11 repeated start
        24'h03_09_11,   // R5 short setup, rise
        24'h09_03_11,   // R6 short hold, rise
        24'h09_09_12    // R2 stop
    };
    localparam string VREQ [9] = '{"R1", "R2", "R5", "R6", "R1", "R11", "R5", "R6", "R2"};

    task automatic frame(input int su, input bit rise, input int hd);
        @(negedge clk); scl = 1'b0;
        wait_ticks(2);
        sda = rise ? 1'b0 : 1'b1;
        wait_ticks(2);
        scl = 1'b1;
        wait_ticks(su);
        sda = rise ? 1'b1 : 1'b0;
        wait_ticks(hd);
        scl = 1'b0;
        wait_ticks(3);
    endtask

    initial begin
        int s0, p0, i0;
        repeat (5) @(negedge clk);
        // R10 reset state
        check(!start_o && !stop_o && !irq_o && !busy_o, "R10", {start_o, stop_o, irq_o, busy_o}, 0);
        rst_n = 1'b1;
        wait_ticks(3);
        check(!busy_o && cnt_irq == 0, "R10", cnt_irq + busy_o, 0);

        for (int v = 0; v < 9; v++) begin
            s0 = cnt_start; p0 = cnt_stop; i0 = cnt_irq;
            frame(int'(VEC[v][23:16]), VEC[v][4], int'(VEC[v][15:8]));
            check(cnt_start - s0 == int'(VEC[v][2]), VREQ[v], cnt_start - s0, int'(VEC[v][2]));
            check(cnt_stop - p0 == int'(VEC[v][1]), VREQ[v], cnt_stop - p0, int'(VEC[v][1]));
            check(cnt_irq - i0 == int'(VEC[v][2]) + int'(VEC[v][1]), "R3",
                  cnt_irq - i0, int'(VEC[v][2]) + int'(VEC[v][1]));
            check(busy_o == VEC[v][0], "R4", busy_o, VEC[v][0]);
        end

        // R7: SDA bounces back inside the hold window
        s0 = cnt_start; i0 = cnt_irq;
        @(negedge clk); scl = 1'b0; wait_ticks(2); sda = 1'b1; wait_ticks(2);
        scl = 1'b1; wait_ticks(9);
        sda = 1'b0; wait_ticks(2);
        sda = 1'b1; wait_ticks(9);
        scl = 1'b0; wait_ticks(3);
        check(cnt_start == s0 && cnt_irq == i0, "R7", cnt_irq - i0, 0);
        check(busy_o == 1'b0, "R7", busy_o, 0);

        // R9: data toggling while SCL is low
        s0 = cnt_start; p0 = cnt_stop;
        for (int k = 0; k < 6; k++) begin
            sda = ~sda; wait_ticks(3);
        end
        check(cnt_start == s0 && cnt_stop == p0, "R9", cnt_start - s0 + cnt_stop - p0, 0);

        // R8: no ticks, long SCL-high window around an edge
        s0 = cnt_start; i0 = cnt_irq;
        sda = 1'b1; wait_ticks(2);
        @(negedge clk); tick_on = 1'b0;
        scl = 1'b1; repeat (60) @(negedge clk);
        sda = 1'b0; repeat (60) @(negedge clk);
        scl = 1'b0; repeat (10) @(negedge clk);
        tick_on = 1'b1; wait_ticks(3);
        check(cnt_start == s0 && cnt_irq == i0, "R8", cnt_irq - i0, 0);
        check(busy_o == 1'b0, "R8", busy_o, 0);

        // R3: pulse widths and irq pairing over the whole run
        check(n_wide == 0, "R3", n_wide, 0);
        check(n_irq_bad == 0, "R3", n_irq_bad, 0);

        // R10: reset while busy
        frame(9, 1'b0, 9);
        check(busy_o == 1'b1, "R1", busy_o, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0 && !irq_o, "R10", busy_o, 0);
        rst_n = 1'b1;
        wait_ticks(3);
        check(busy_o == 1'b0, "R10", busy_o, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule